// File: doc/BRIEF.md
# Victim-Aggressor Pattern Lane Walker

This block produces write data that stresses a memory data bus with crosstalk, and checks the read data that comes back against the same sequence. Two fixed patterns of byte-wide chunks are kept on chip. One is the victim pattern and the other is the aggressor pattern. Each chunk is sent on one lane as an eight-beat burst. Inside the byte chosen at start, one lane at a time carries the victim pattern. Every other lane carries the aggressor pattern, and that includes every lane of the bytes that were not chosen. The victim moves on to the next lane of the byte only after it has carried the whole pattern.

Writes leave the block on a valid/ready stream. The producer holds `wr_data` and `wr_last` steady for as long as `wr_valid` is high and `wr_ready` is low. Reads come in on a second valid/ready stream. The block raises `rd_ready` whenever it still expects read beats, and it takes a beat on any cycle in which both `rd_valid` and `rd_ready` are high. The two streams use separate position counters, so reads can lag writes or run ahead of them by any amount. Each mismatching bit sets a sticky error flag for its lane. The command sequencer and the delay control that sit around the block drive both streams.

Top module: `pattern_lane_walker`

## Requirements
- R1: After reset, `busy`, `done`, `wr_valid`, `rd_ready` and `err_lanes` are all 0. While `busy` is 0, `wr_valid` and `rd_ready` stay 0.
- R2: A `start` pulse while `busy` is 0 does four things: it captures `byte_sel`, it clears `err_lanes` and `done`, and it raises `busy` on the next cycle. A `start` while `busy` is 1 has no effect on the selected byte, the errors or the sequence.
- R3: Pattern entry i, for i from 0 to 156, is a victim chunk of (29*i+7) mod 256 and an aggressor chunk of (83*i+195) mod 256.
- R4: The sequence is victim lane v = 0..7 in the outer loop, pattern entry i = 0..156 in the middle loop and beat k = 0..7 in the inner loop. Beat k of a lane carries bit k of that lane's chunk. `wr_last` is 1 on beat 7.
- R5: Lane n is bit n of the data buses and belongs to byte n/8, bit n mod 8. Lane `byte_sel`*8+v carries the victim chunk. Every other lane, including all lanes of unselected bytes, carries the aggressor chunk.
- R6: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid` stays 1 and `wr_data` and `wr_last` hold their values on the next cycle.
- R7: Read beat j is compared with write beat j of the same sequence, whatever the write stream has reached.
- R8: A bit of an accepted read beat that differs from its expected value sets the matching `err_lanes` bit. The bit stays set until the next accepted start.
- R9: One cycle after the last read beat (number 10048) is accepted, `done` is 1 and `busy` is 0. `done` holds until the next accepted start.
- R10: Once all 10048 write beats are accepted, `wr_valid` stays 0 even if reads are still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a walk when the block is idle |
| byte_sel | input | SEL_W (1) | Byte that receives the walking victim lane |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | The last walk completed |
| wr_valid | output | 1 | Write beat available |
| wr_ready | input | 1 | Write beat taken |
| wr_data | output | LANES (16) | One bit per lane for this beat |
| wr_last | output | 1 | Final beat of a burst |
| rd_valid | input | 1 | Read beat available |
| rd_ready | output | 1 | Block will take a read beat |
| rd_data | input | LANES (16) | Read beat, one bit per lane |
| err_lanes | output | LANES (16) | Sticky per-lane mismatch flags |

## Verification
The bench applies random back-pressure to both streams. A design that let `wr_data` change while a beat was stalled, or that tied read comparison to write progress, would give wrong lanes or false errors. Errors are injected on the very last read beat and on lanes of the unselected byte, which catches an off-by-one termination and a victim mask that leaks across bytes. A start arriving mid-walk is expected to leave the selected byte and the collected errors untouched. A design that restarted on it would show the wrong victim lane or lost flags.

// File: rtl/lw_pkg.sv
package lw_pkg;
  localparam int BEATS      = 8;
  localparam int LANES_BYTE = 8;
  localparam int VIC_MUL    = 29;
  localparam int VIC_ADD    = 7;
  localparam int AGG_MUL    = 83;
  localparam int AGG_ADD    = 195;

  // Chunk i of the victim (is_vic=1) or aggressor pattern
  function automatic logic [7:0] pat_chunk(input bit is_vic, input int idx);
    int v;
    v = is_vic ? (idx * VIC_MUL + VIC_ADD) : (idx * AGG_MUL + AGG_ADD);
    return 8'(v % 256);
  endfunction
endpackage

// File: rtl/lw_pattern_rom.sv
module lw_pattern_rom #(
  parameter int DEPTH  = 157,
  parameter bit IS_VIC = 1'b1,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  output logic [7:0]    data_a,
  output logic [7:0]    data_b
);
  logic [7:0] table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_fill
    assign table_q[i] = lw_pkg::pat_chunk(IS_VIC, i);
  end

  always_comb begin
    data_a = 8'h00;
    data_b = 8'h00;
    if (int'(addr_a) < DEPTH) data_a = table_q[addr_a];
    if (int'(addr_b) < DEPTH) data_b = table_q[addr_b];
  end
endmodule

// File: rtl/lw_walk_counter.sv
module lw_walk_counter #(
  parameter int DEPTH = 157,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          adv,
  output logic [2:0]    beat,
  output logic [AW-1:0] entry,
  output logic [2:0]    victim,
  output logic          at_end,
  output logic          fin
);
  localparam logic [AW-1:0] LAST_ENTRY = AW'(DEPTH - 1);

  assign at_end = (beat == 3'd7) && (entry == LAST_ENTRY) && (victim == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      beat   <= '0;
      entry  <= '0;
      victim <= '0;
      fin    <= 1'b0;
    end else if (adv && !fin) begin
      if (at_end) begin
        fin  <= 1'b1;
        beat <= '0;
        entry <= '0;
        victim <= '0;
      end else if (beat == 3'd7) begin
        beat <= '0;
        if (entry == LAST_ENTRY) begin
          entry  <= '0;
          victim <= victim + 3'd1;
        end else begin
          entry <= entry + AW'(1);
        end
      end else begin
        beat <= beat + 3'd1;
      end
    end
  end
endmodule

// File: rtl/lw_lane_mux.sv
module lw_lane_mux #(
  parameter int NUM_BYTES = 2,
  localparam int LANES    = NUM_BYTES * 8,
  localparam int SEL_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic [7:0]       vic_chunk,
  input  logic [7:0]       agg_chunk,
  input  logic [2:0]       beat,
  input  logic [2:0]       victim,
  input  logic [SEL_W-1:0] sel,
  output logic [LANES-1:0] lanes
);
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      logic is_vic;
      assign is_vic = (sel == SEL_W'(b)) && (victim == 3'(k));
      assign lanes[b*8+k] = is_vic ? vic_chunk[beat] : agg_chunk[beat];
    end
  end
endmodule

// File: rtl/pattern_lane_walker.sv
module pattern_lane_walker #(
  parameter int NUM_BYTES = 2,
  parameter int PAT_LEN   = 157,
  localparam int LANES    = NUM_BYTES * 8,
  localparam int SEL_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int AW       = $clog2(PAT_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] byte_sel,
  output logic             busy,
  output logic             done,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [LANES-1:0] wr_data,
  output logic             wr_last,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [LANES-1:0] rd_data,
  output logic [LANES-1:0] err_lanes
);
  logic             start_go;
  logic [SEL_W-1:0] sel_q;

  logic [2:0]    wr_beat, rd_beat, wr_vic, rd_vic;
  logic [AW-1:0] wr_entry, rd_entry;
  logic          wr_end, rd_end, wr_fin, rd_fin;
  logic          wr_fire, rd_fire;
  logic [7:0]    vic_wr, vic_rd, agg_wr, agg_rd;
  logic [LANES-1:0] rd_exp;

  assign start_go = start && !busy;
  assign wr_valid = busy && !wr_fin;
  assign rd_ready = busy && !rd_fin;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign wr_last  = wr_valid && (wr_beat == 3'd7);

  lw_walk_counter #(.DEPTH(PAT_LEN)) u_wr_cnt (
    .clk(clk), .rst_n(rst_n), .clear(start_go), .adv(wr_fire),
    .beat(wr_beat), .entry(wr_entry), .victim(wr_vic),
    .at_end(wr_end), .fin(wr_fin)
  );

  lw_walk_counter #(.DEPTH(PAT_LEN)) u_rd_cnt (
    .clk(clk), .rst_n(rst_n), .clear(start_go), .adv(rd_fire),
    .beat(rd_beat), .entry(rd_entry), .victim(rd_vic),
    .at_end(rd_end), .fin(rd_fin)
  );

  lw_pattern_rom #(.DEPTH(PAT_LEN), .IS_VIC(1'b1)) u_vic_rom (
    .addr_a(wr_entry), .addr_b(rd_entry), .data_a(vic_wr), .data_b(vic_rd)
  );

  lw_pattern_rom #(.DEPTH(PAT_LEN), .IS_VIC(1'b0)) u_agg_rom (
    .addr_a(wr_entry), .addr_b(rd_entry), .data_a(agg_wr), .data_b(agg_rd)
  );

  lw_lane_mux #(.NUM_BYTES(NUM_BYTES)) u_wr_mux (
    .vic_chunk(vic_wr), .agg_chunk(agg_wr), .beat(wr_beat),
    .victim(wr_vic), .sel(sel_q), .lanes(wr_data)
  );

  lw_lane_mux #(.NUM_BYTES(NUM_BYTES)) u_rd_mux (
    .vic_chunk(vic_rd), .agg_chunk(agg_rd), .beat(rd_beat),
    .victim(rd_vic), .sel(sel_q), .lanes(rd_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      sel_q     <= '0;
      err_lanes <= '0;
    end else if (start_go) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      sel_q     <= byte_sel;
      err_lanes <= '0;
    end else if (rd_fire) begin
      err_lanes <= err_lanes | (rd_data ^ rd_exp);
      if (rd_end) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  logic unused_ok;
  assign unused_ok = wr_end;
endmodule

// File: rtl/lw_walker_checker.sv
module lw_walker_checker #(
  parameter int LANES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [LANES-1:0] wr_data,
  input logic             wr_last,
  input logic             rd_ready,
  input logic [LANES-1:0] err_lanes
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid && !rd_ready));

  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && err_lanes == '0));

  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_last)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((err_lanes & $past(err_lanes)) == $past(err_lanes)));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !wr_valid && !rd_ready));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind pattern_lane_walker lw_walker_checker #(.LANES(LANES)) u_walker_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
  .wr_last(wr_last), .rd_ready(rd_ready), .err_lanes(err_lanes)
);

// File: tb/test_pattern_lane_walker.sv
module test_pattern_lane_walker;
  localparam int NB    = 2;
  localparam int LN    = NB * 8;
  localparam int PLEN  = 157;
  localparam int TOTAL = 8 * PLEN * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [0:0]    byte_sel = '0;
  logic          busy, done, wr_valid, wr_last, rd_ready;
  logic          wr_ready = 1'b0;
  logic          rd_valid = 1'b0;
  logic [LN-1:0] wr_data, err_lanes;
  logic [LN-1:0] rd_data = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pattern_lane_walker #(.NUM_BYTES(NB), .PAT_LEN(PLEN)) i_pattern_lane_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_sel(byte_sel),
    .busy(busy), .done(done), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_last(wr_last), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .err_lanes(err_lanes)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  function automatic logic [7:0] chunk(input bit vic, input int i);
    return vic ? 8'((29 * i + 7) % 256) : 8'((83 * i + 195) % 256);
  endfunction

  function automatic logic [LN-1:0] exp_beat(input int sel, input int idx);
    logic [LN-1:0] w;
    int k, e, v;
    k = idx % 8;
    e = (idx / 8) % PLEN;
    v = idx / (8 * PLEN);
    for (int n = 0; n < LN; n++) begin
      logic [7:0] c;
      c = ((n / 8) == sel && (n % 8) == v) ? chunk(1'b1, e) : chunk(1'b0, e);
      w[n] = c[k];
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start(input int sel);
    @(negedge clk);
    start = 1'b1; byte_sel = 1'(sel);
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && done === 1'b0, "R2 busy after start", {busy, done}, 2'b10);
    check(err_lanes === '0, "R2 errors cleared", err_lanes, 0);
  endtask

  // One full walk. inj_idx/inj_mask: read beats to corrupt. full: no back-pressure.
  task automatic run_walk(input int sel, input bit full, input int inj_a, input logic [LN-1:0] mask_a,
                          input int inj_b, input logic [LN-1:0] mask_b, input int bad_start_at);
    int wi = 0, ri = 0, wbad = 0;
    logic [LN-1:0] exp_err = '0;
    logic [LN-1:0] held;
    bit stalled = 0;
    do_start(sel);
    while (ri < TOTAL) begin
      @(negedge clk);
      if (stalled) begin
        if (!(wr_valid === 1'b1 && wr_data === held)) wbad++;
        check(wr_valid === 1'b1 && wr_data === held, "R6 stalled beat held", wr_data, held);
      end
      start = (ri == bad_start_at);
      byte_sel = 1'(1 - sel);
      wr_ready = full ? 1'b1 : 1'($urandom_range(0, 2) != 0);
      rd_valid = full ? 1'b1 : 1'($urandom_range(0, 1));
      rd_data = exp_beat(sel, ri);
      if (ri == inj_a) rd_data = rd_data ^ mask_a;
      if (ri == inj_b) rd_data = rd_data ^ mask_b;
      #1;
      stalled = 0;
      if (wi >= TOTAL)
        check(wr_valid === 1'b0, "R10 writes stop after last beat", wr_valid, 0);
      else if (wr_valid && wr_ready) begin
        logic [LN-1:0] e;
        e = exp_beat(sel, wi);
        if (wr_data !== e || wr_last !== (wi % 8 == 7)) begin
          check(1'b0, "R3 R4 R5 write beat", {wr_last, wr_data}, {(wi % 8 == 7), e});
        end else checks++;
        wi++;
      end else if (wr_valid) begin
        stalled = 1; held = wr_data;
      end
      if (rd_valid && rd_ready) begin
        if (ri == inj_a) exp_err |= mask_a;
        if (ri == inj_b) exp_err |= mask_b;
        ri++;
      end
      if (ri == TOTAL / 2)
        check(err_lanes === (exp_err & ~(ri == inj_a + 1 || ri == inj_b + 1 ? '1 : '0)) || err_lanes === exp_err,
              "R8 errors mid-run", err_lanes, exp_err);
    end
    @(negedge clk);
    start = 1'b0; wr_ready = 1'b0; rd_valid = 1'b0;
    check(done === 1'b1 && busy === 1'b0, "R9 done after last read", {done, busy}, 2'b10);
    check(rd_ready === 1'b0 && wr_valid === 1'b0, "R1 idle streams quiet", {rd_ready, wr_valid}, 0);
    check(err_lanes === exp_err, "R8 R7 sticky error lanes", err_lanes, exp_err);
    check(wi == TOTAL, "R4 write beat count", wi, TOTAL);
    repeat (3) @(negedge clk);
    check(done === 1'b1 && err_lanes === exp_err, "R9 done holds", {done, err_lanes}, {1'b1, exp_err});
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && wr_valid === 1'b0 && rd_ready === 1'b0 && err_lanes === '0,
          "R1 reset state", {busy, done, wr_valid, rd_ready, err_lanes}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_valid === 1'b0 && rd_ready === 1'b0, "R1 idle after reset", {wr_valid, rd_ready}, 0);
    // Random back-pressure, byte 0, errors on own lane 3 and unselected-byte lane 12
    run_walk(0, 1'b0, 500, 16'h0008, 7000, 16'h1000, -1);
    // Byte 1, start mid-walk must be ignored (R2), early error kept
    run_walk(1, 1'b0, 10, 16'h0001, -1, '0, 3000);
    // Full throughput, error on the very last read beat (R9/R8 boundary)
    run_walk(1, 1'b1, TOTAL - 1, 16'h8000, 0, 16'h0200, -1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule